// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block tracks row state and command spacing for a DRAM device with sixteen banks, arranged as four groups of four. Each bank has one request slot. A slot holds a candidate command (activate, read, write or precharge) and, for an activate, the row to open. Every cycle the block reports which candidates could legally go out to the device in that cycle. It grants at most one of them. It then updates the open-row state and the countdown timers on the granted command.

Two kinds of timing apply. Each bank has its own timers: activate to column access, precharge to activate, and read or write to precharge. Each bank group has its own timers for activate-to-activate, column-to-column and write-to-read spacing. Those group timers are loaded with a long value when the command goes to the same group and a short value when it goes to a different group. All spacing values come in on configuration inputs and are held stable while the block runs. A surrounding scheduler uses the legality and grant vectors. This block does not reorder requests and does not move data.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank is closed, `open_rows` is zero, and no request is legal or granted while no request is valid.
- R2: A granted activate (command code 0) sets the bank's bit in `bank_open` on the next cycle and stores the request row in that bank's field of `open_rows`. The field for bank b is bits [17b+16:17b].
- R3: A read (code 1) or write (code 2) is legal only to a bank whose row is open. Column requests to a closed bank are never granted.
- R4: An activate to a bank that is already open raises that bank's bit in `bad_act` and is not granted. It leaves `bank_open` and the stored row unchanged.
- R5: A granted precharge (code 3) to an open bank closes it on the next cycle. A precharge to a closed bank is granted as a no-op and changes no state.
- R6: Same-bank spacing from grant to grant, in cycles, is max(value,1) for each rule: activate to read or write is `t_rcd`, precharge to activate is `t_rp`, read to precharge is `t_rtp`, and write to precharge is `t_wtp`.
- R7: Activate-to-activate spacing is `t_rrd_l` within one bank group and `t_rrd_s` across groups. The group of bank b is b/4.
- R8: Spacing between column commands (read or write) is `t_ccd_l` within one group and `t_ccd_s` across groups.
- R9: Write-to-read spacing is `t_wtr_l` within one group and `t_wtr_s` across groups. It combines with R8 by taking the larger value.
- R10: `legal` flags every valid request that may issue. `grant` is one-hot or zero and selects the lowest-indexed legal bank.
- R11: A bank still waiting on its own timers does not block a command to another bank. Once group spacing allows it, the other bank is granted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 16 | One candidate valid per bank |
| req_cmd | input | 32 | Two-bit command per bank: 0 activate, 1 read, 2 write, 3 precharge |
| req_row | input | 272 | 17-bit row per bank, used by activate |
| t_rcd | input | 6 | Activate to column, same bank |
| t_rp | input | 6 | Precharge to activate, same bank |
| t_rtp | input | 6 | Read to precharge, same bank |
| t_wtp | input | 6 | Write to precharge, same bank |
| t_rrd_l | input | 6 | Activate to activate, same group |
| t_rrd_s | input | 6 | Activate to activate, other group |
| t_ccd_l | input | 6 | Column to column, same group |
| t_ccd_s | input | 6 | Column to column, other group |
| t_wtr_l | input | 6 | Write to read, same group |
| t_wtr_s | input | 6 | Write to read, other group |
| legal | output | 16 | Request may issue this cycle |
| grant | output | 16 | Request issued this cycle |
| bad_act | output | 16 | Activate aimed at an already open bank |
| bank_open | output | 16 | Bank currently holds an open row |
| open_rows | output | 272 | Stored row per bank |

## Verification
On every cycle the assertions check several local rules. A granted activate opens its bank with the requested row, and a granted precharge closes an open bank. A flagged activate leaves the bank untouched. Column grants only reach open banks, and the grant never carries more than one bit. They also check that the next cycle after an activate holds no column grant to that bank when `t_rcd` exceeds one, and no second activate in that group when `t_rrd_l` exceeds one. Only the bench scenarios can show the exact spacing counts for each per-bank and per-group rule, the long and short split between groups, the combined write-to-read and column spacing, and the lowest-index choice among several legal requests.

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int NGRP = 4,
  parameter int BPG  = 4,
  parameter int ROWW = 17,
  parameter int TW   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NGRP*BPG-1:0]       req_valid,
  input  logic [2*NGRP*BPG-1:0]     req_cmd,
  input  logic [ROWW*NGRP*BPG-1:0]  req_row,
  input  logic [TW-1:0]             t_rcd,
  input  logic [TW-1:0]             t_rp,
  input  logic [TW-1:0]             t_rtp,
  input  logic [TW-1:0]             t_wtp,
  input  logic [TW-1:0]             t_rrd_l,
  input  logic [TW-1:0]             t_rrd_s,
  input  logic [TW-1:0]             t_ccd_l,
  input  logic [TW-1:0]             t_ccd_s,
  input  logic [TW-1:0]             t_wtr_l,
  input  logic [TW-1:0]             t_wtr_s,
  output logic [NGRP*BPG-1:0]       legal,
  output logic [NGRP*BPG-1:0]       grant,
  output logic [NGRP*BPG-1:0]       bad_act,
  output logic [NGRP*BPG-1:0]       bank_open,
  output logic [ROWW*NGRP*BPG-1:0]  open_rows
);
  localparam int NBANK = NGRP * BPG;
  localparam logic [1:0] C_ACT = 2'd0;
  localparam logic [1:0] C_RD  = 2'd1;
  localparam logic [1:0] C_WR  = 2'd2;
  localparam logic [1:0] C_PRE = 2'd3;

  logic [NBANK-1:0] open_q;
  logic [ROWW-1:0]  row_q  [NBANK];
  logic [TW-1:0]    actw_q [NBANK];
  logic [TW-1:0]    colw_q [NBANK];
  logic [TW-1:0]    prew_q [NBANK];
  logic [TW-1:0]    rrd_q  [NGRP];
  logic [TW-1:0]    ccd_q  [NGRP];
  logic [TW-1:0]    wtr_q  [NGRP];

  logic [NBANK-1:0] is_act;
  logic [NGRP-1:0]  grp_hit;
  logic [NGRP-1:0]  grp_act;
  logic [1:0]       iss_cmd;
  logic             iss_any;

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] cur, input logic ld,
                                        input logic [TW-1:0] t);
    logic [TW-1:0] d, l;
    d = (cur == '0) ? '0 : cur - 1'b1;
    l = (t == '0) ? '0 : t - 1'b1;
    return (ld && l > d) ? l : d;
  endfunction

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int G = b / BPG;
    logic [1:0] c;
    logic ok;
    assign c = req_cmd[2*b +: 2];
    assign is_act[b] = (c == C_ACT);
    always_comb begin
      case (c)
        C_ACT:   ok = !open_q[b] && actw_q[b] == '0 && rrd_q[G] == '0;
        C_RD:    ok = open_q[b] && colw_q[b] == '0 && ccd_q[G] == '0 && wtr_q[G] == '0;
        C_WR:    ok = open_q[b] && colw_q[b] == '0 && ccd_q[G] == '0;
        default: ok = !open_q[b] || prew_q[b] == '0;
      endcase
    end
    assign legal[b]   = req_valid[b] && ok;
    assign bad_act[b] = req_valid[b] && (c == C_ACT) && open_q[b];
    assign open_rows[ROWW*b +: ROWW] = row_q[b];

    // R2
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[b] && c == C_ACT) |=> (open_q[b] && row_q[b] == $past(req_row[ROWW*b +: ROWW])));
    // R5
    pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[b] && c == C_PRE) |=> !open_q[b]);
    // R4
    bad_act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_act[b] |=> (open_q[b] && $stable(row_q[b])));
    // R3
    col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[b] && (c == C_RD || c == C_WR)) |-> open_q[b]);
    // R6
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[b] && c == C_ACT && t_rcd > 1) |=> !(grant[b] && (c == C_RD || c == C_WR)));
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_hit[g] = |grant[g*BPG +: BPG];
    assign grp_act[g] = |(grant[g*BPG +: BPG] & is_act[g*BPG +: BPG]);
    // R7
    rrd_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_act[g] && t_rrd_l > 1) |=> !grp_act[g]);
  end

  always_comb begin
    grant   = '0;
    iss_any = 1'b0;
    iss_cmd = C_ACT;
    for (int b = 0; b < NBANK; b++) begin
      if (legal[b] && !iss_any) begin
        grant[b] = 1'b1;
        iss_any  = 1'b1;
        iss_cmd  = req_cmd[2*b +: 2];
      end
    end
  end

  assign bank_open = open_q;

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int b = 0; b < NBANK; b++) begin
        row_q[b]  <= '0;
        actw_q[b] <= '0;
        colw_q[b] <= '0;
        prew_q[b] <= '0;
      end
      for (int g = 0; g < NGRP; g++) begin
        rrd_q[g] <= '0;
        ccd_q[g] <= '0;
        wtr_q[g] <= '0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        actw_q[b] <= nxt(actw_q[b], grant[b] && iss_cmd == C_PRE && open_q[b], t_rp);
        colw_q[b] <= nxt(colw_q[b], grant[b] && iss_cmd == C_ACT, t_rcd);
        prew_q[b] <= nxt(prew_q[b], grant[b] && (iss_cmd == C_RD || iss_cmd == C_WR),
                         (iss_cmd == C_WR) ? t_wtp : t_rtp);
        if (grant[b] && iss_cmd == C_ACT) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= req_row[ROWW*b +: ROWW];
        end else if (grant[b] && iss_cmd == C_PRE && open_q[b]) begin
          open_q[b] <= 1'b0;
          row_q[b]  <= '0;
        end
      end
      for (int g = 0; g < NGRP; g++) begin
        rrd_q[g] <= nxt(rrd_q[g], iss_any && iss_cmd == C_ACT,
                        grp_hit[g] ? t_rrd_l : t_rrd_s);
        ccd_q[g] <= nxt(ccd_q[g], iss_any && (iss_cmd == C_RD || iss_cmd == C_WR),
                        grp_hit[g] ? t_ccd_l : t_ccd_s);
        wtr_q[g] <= nxt(wtr_q[g], iss_any && iss_cmd == C_WR,
                        grp_hit[g] ? t_wtr_l : t_wtr_s);
      end
    end
  end
endmodule

// File: tb/dram_bank_tracker_tb_top.sv
module dram_bank_tracker_tb_top;
  localparam int NB = 16;
  localparam int RW = 17;
  localparam logic [1:0] ACT = 2'd0, RD = 2'd1, WR = 2'd2, PRE = 2'd3;

  logic clk = 0, rst_n = 0;
  logic [NB-1:0] req_valid;
  logic [2*NB-1:0] req_cmd;
  logic [RW*NB-1:0] req_row;
  logic [5:0] t_rcd = 4, t_rp = 4, t_rtp = 2, t_wtp = 6;
  logic [5:0] t_rrd_l = 6, t_rrd_s = 4, t_ccd_l = 6, t_ccd_s = 4, t_wtr_l = 8, t_wtr_s = 5;
  logic [NB-1:0] legal, grant, bad_act, bank_open;
  logic [RW*NB-1:0] open_rows;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dram_bank_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_row(req_row),
    .t_rcd(t_rcd), .t_rp(t_rp), .t_rtp(t_rtp), .t_wtp(t_wtp),
    .t_rrd_l(t_rrd_l), .t_rrd_s(t_rrd_s), .t_ccd_l(t_ccd_l), .t_ccd_s(t_ccd_s),
    .t_wtr_l(t_wtr_l), .t_wtr_s(t_wtr_s),
    .legal(legal), .grant(grant), .bad_act(bad_act), .bank_open(bank_open),
    .open_rows(open_rows));

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic clr();
    req_valid = '0; req_cmd = '0; req_row = '0;
  endtask

  task automatic set_req(input int b, input logic [1:0] c, input logic [RW-1:0] r);
    req_valid[b] = 1'b1; req_cmd[2*b +: 2] = c; req_row[RW*b +: RW] = r;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    clr();
    repeat (n) step();
  endtask

  task automatic issue(input int b, input logic [1:0] c, input logic [RW-1:0] r, input string tag);
    clr(); set_req(b, c, r); #1;
    check(tag, int'(grant[b]), 1);
    step(); clr();
  endtask

  task automatic measure(input int b1, input logic [1:0] c1, input int b2, input logic [1:0] c2,
                         input int exp, input string tag);
    int n;
    issue(b1, c1, 17'h11, {tag, " first"});
    set_req(b2, c2, 17'h22);
    n = 1;
    while (n < 40) begin
      #1;
      if (grant[b2]) break;
      step(); n++;
    end
    step(); clr();
    check(tag, n, exp);
    idle(20);
  endtask

  task automatic t_reset();
    check("R1 open", int'(bank_open), 0);
    check("R1 rows", int'(|open_rows), 0);
    check("R1 grant", int'(grant), 0);
    check("R1 legal", int'(legal), 0);
  endtask

  task automatic t_act();
    issue(0, ACT, 17'h123, "R2 act grant");
    check("R2 open", int'(bank_open[0]), 1);
    check("R2 row", int'(open_rows[0 +: RW]), 'h123);
    idle(10);
  endtask

  task automatic t_closed_col();
    clr(); set_req(5, RD, 0); set_req(6, WR, 0);
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R3 rd closed legal", int'(legal[5]), 0);
      check("R3 wr closed grant", int'(grant), 0);
      step();
    end
    clr();
    check("R3 state", int'(bank_open), 1);
  endtask

  task automatic t_bad_act();
    clr(); set_req(0, ACT, 17'h55); #1;
    check("R4 flag", int'(bad_act[0]), 1);
    check("R4 no grant", int'(grant), 0);
    step(); clr();
    check("R4 open kept", int'(bank_open[0]), 1);
    check("R4 row kept", int'(open_rows[0 +: RW]), 'h123);
  endtask

  task automatic t_pre();
    issue(0, PRE, 0, "R5 pre grant");
    check("R5 closed", int'(bank_open[0]), 0);
    issue(7, PRE, 0, "R5 noop grant");
    check("R5 noop state", int'(bank_open), 0);
    idle(10);
  endtask

  task automatic t_bank_spacing();
    measure(1, ACT, 1, RD, 4, "R6 act-rd");
    measure(1, RD, 1, PRE, 2, "R6 rd-pre");
    issue(1, ACT, 17'h7, "R6 reopen"); idle(20);
    measure(1, WR, 1, PRE, 6, "R6 wr-pre");
    issue(1, ACT, 17'h8, "R6 reopen2"); idle(20);
    measure(1, PRE, 1, ACT, 4, "R6 pre-act");
  endtask

  task automatic t_group_spacing();
    measure(2, ACT, 3, ACT, 6, "R7 rrd long");
    measure(8, ACT, 12, ACT, 4, "R7 rrd short");
    measure(2, RD, 3, RD, 6, "R8 ccd long");
    measure(8, RD, 12, RD, 4, "R8 ccd short");
    measure(2, WR, 3, RD, 8, "R9 wtr long");
    measure(8, WR, 12, RD, 5, "R9 wtr short");
  endtask

  task automatic t_priority();
    clr(); set_req(12, RD, 0); set_req(3, RD, 0); set_req(2, RD, 0); #1;
    check("R10 legal", int'(legal), (1 << 2) | (1 << 3) | (1 << 12));
    check("R10 grant", int'(grant), 1 << 2);
    step(); idle(20);
  endtask

  task automatic t_concurrency();
    measure(13, ACT, 8, RD, 1, "R11 other bank");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_act();
    t_closed_col();
    t_bad_act();
    t_pre();
    t_bank_spacing();
    t_group_spacing();
    t_priority();
    t_concurrency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule